// File: doc/BRIEF.md
# Page Write and Completion Polling Engine

This block is the host side of a byte-wide, self-timed nonvolatile memory. A single start request gives a page base address, a byte count and a polling method. The engine then takes the page bytes from a local buffer over a valid/ready stream and writes each one to the memory bus with programmable setup, pulse and hold counts. After the last byte it polls the device until the internal programming cycle has ended, or until a timeout expires, and reports done or an error code.

Two completion tests are available. The data test rereads the last address written and waits until bit 7 equals bit 7 of the last byte written. While the device is busy, that bit reads back inverted. The toggle test reads twice in a row and waits until bit 6 stops changing. When the protect input is set, a three-write unlock preamble goes out before the data bytes.

The byte stream has these rules. `in_ready` is high only while the engine waits for the next page byte. A byte moves in any cycle where `in_valid` and `in_ready` are both high. The source may hold `in_valid` low for as long as it likes before the first write of a request. After the first write, the next byte must arrive within `WIN_CYCLES` of the previous write strobe falling edge. Otherwise the request is aborted, because a device would start programming a partial page.

Top module: `page_write_poller`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high, and `busy`, `in_ready`, `done` and `err` are low.
- R2: A start with a byte count of 0 or above `PAGE_BYTES` gives err_code 1. A start where the base offset within the page plus the count exceeds `PAGE_BYTES` gives err_code 2. In both cases `err` rises in the cycle after start and no bus write occurs.
- R3: Every bus write has three phases, with `mem_oe_n` high throughout. Chip enable is low with write enable high for `t_setup`+1 cycles. Write enable is then low for `t_pulse`+1 cycles. Chip enable then stays low for `t_hold`+1 cycles after write enable rises. Address and data hold steady for the whole write.
- R4: Byte k of a request is written to base+k, in stream order. The page bits (address bits above the in-page offset) stay equal to those of the base address throughout. `in_ready` is high only while no bus cycle is in flight.
- R5: With `protect_en` set, three writes precede the data: 0xAA to 0x1555, then 0x55 to 0x0AAA, then 0xA0 to 0x1555.
- R6: If the next byte has not arrived within `WIN_CYCLES` of the previous write-enable falling edge, the engine releases the bus and reports err_code 4. Only the bytes already accepted are written.
- R7: In data mode (`poll_toggle`=0), each poll is a read of the last address written. Chip enable and output enable are low for `t_read`+1 cycles. `done` is reported only once bit 7 read equals bit 7 of the last byte written.
- R8: In toggle mode (`poll_toggle`=1), `done` is reported only once two consecutive reads return the same bit 6.
- R9: If completion is not seen within `TMO_CYCLES` of polling start, the engine reports err_code 3.
- R10: `done` and `err` are single-cycle pulses. They are never high together, and `busy` is already low when either is high.
- R11: A start that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| poll_toggle | input | 1 | 0: bit-7 data test, 1: bit-6 toggle test |
| protect_en | input | 1 | Send the unlock preamble first |
| base_addr | input | AW | First byte address of the request |
| byte_cnt | input | CW | Number of bytes (1..PAGE_BYTES) |
| t_setup | input | TW | Setup phase length minus one |
| t_pulse | input | TW | Write pulse length minus one |
| t_hold | input | TW | Hold phase length minus one |
| t_read | input | TW | Read strobe length minus one |
| in_valid | input | 1 | Page byte present |
| in_ready | output | 1 | Engine takes a page byte |
| in_data | input | 8 | Page byte |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_drive | output | 1 | Host drives the data bus |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Error pulse |
| err_code | output | 3 | 0 none, 1 count, 2 page cross, 3 timeout, 4 stream stall |

## Verification
The hardest states to reach from the ports are the ends of polling. These are a toggle test that sees one unequal pair and then an equal pair, a data test that runs long enough to hit the timeout, and a stream stall partway through a page. The bench holds a behavioural device whose busy time is set per request. While busy, that device inverts bit 7 and flips bit 6 on every read. Choosing a busy time below or above the timeout steers each request to completion or to error. Withholding `in_valid` past the window after a chosen byte forces the stall path.

// File: rtl/pgp_pkg.sv
package pgp_pkg;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_COUNT   = 3'd1,
    ERR_PAGE    = 3'd2,
    ERR_TIMEOUT = 3'd3,
    ERR_STALL   = 3'd4
  } err_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD, PH_READ, PH_GAP
  } phase_e;

  typedef enum logic [2:0] {
    S_IDLE, S_UNLK, S_UNLKW, S_WAIT, S_WR, S_PRD, S_PRDW
  } eng_state_e;

  localparam logic [1:0] UNLK_LAST = 2'd2;

  function automatic logic [15:0] unlock_addr(input logic [1:0] i);
    return (i == 2'd1) ? 16'h0AAA : 16'h1555;
  endfunction

  function automatic logic [7:0] unlock_data(input logic [1:0] i);
    case (i)
      2'd0:    return 8'hAA;
      2'd1:    return 8'h55;
      default: return 8'hA0;
    endcase
  endfunction

endpackage

// File: rtl/pgp_limit_timer.sv
module pgp_limit_timer #(
  parameter int LIMIT = 1000,
  localparam int CNW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam logic [CNW-1:0] LIM = LIMIT[CNW-1:0];
  logic [CNW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (restart)            cnt <= '0;
    else if (run && cnt != LIM)  cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);

  // the count saturates: once expired it stays expired until restarted (R9)
  p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !restart) |=> expired);
endmodule

// File: rtl/pgp_req_check.sv
module pgp_req_check
  import pgp_pkg::*;
#(
  parameter int AW = 13,
  parameter int PAGE_BYTES = 64,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int CW = PW + 1
) (
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] cnt,
  output err_e          code
);
  localparam logic [CW:0] PAGE_L = PAGE_BYTES[CW:0];
  logic [CW:0] span;

  assign span = {2'b00, base[PW-1:0]} + {1'b0, cnt};

  always_comb begin
    if (cnt == '0 || {1'b0, cnt} > PAGE_L) code = ERR_COUNT;
    else if (span > PAGE_L)                code = ERR_PAGE;
    else                                   code = ERR_NONE;
  end
endmodule

// File: rtl/pgp_bus_cycle.sv
module pgp_bus_cycle
  import pgp_pkg::*;
#(
  parameter int AW = 13,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic [TW-1:0] t_setup,
  input  logic [TW-1:0] t_pulse,
  input  logic [TW-1:0] t_hold,
  input  logic [TW-1:0] t_read,
  input  logic [7:0]    bus_rdata,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          drive,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  output logic          fin,
  output logic          we_fall,
  output logic [7:0]    rd_q
);
  phase_e        ph;
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE; cnt <= '0; fin <= 1'b0; we_fall <= 1'b0;
      bus_addr <= '0; bus_wdata <= '0; rd_q <= '0;
    end else begin
      fin     <= 1'b0;
      we_fall <= 1'b0;
      case (ph)
        PH_IDLE: if (go) begin
          bus_addr  <= addr;
          bus_wdata <= wdata;
          if (rd) begin ph <= PH_READ;  cnt <= t_read;  end
          else    begin ph <= PH_SETUP; cnt <= t_setup; end
        end
        PH_SETUP: if (cnt == '0) begin ph <= PH_PULSE; cnt <= t_pulse; we_fall <= 1'b1; end
                  else cnt <= cnt - 1'b1;
        PH_PULSE: if (cnt == '0) begin ph <= PH_HOLD; cnt <= t_hold; end
                  else cnt <= cnt - 1'b1;
        PH_HOLD:  if (cnt == '0) begin ph <= PH_IDLE; fin <= 1'b1; end
                  else cnt <= cnt - 1'b1;
        PH_READ:  if (cnt == '0) begin ph <= PH_GAP; rd_q <= bus_rdata; end
                  else cnt <= cnt - 1'b1;
        PH_GAP:   begin ph <= PH_IDLE; fin <= 1'b1; end
        default:  ph <= PH_IDLE;
      endcase
    end
  end

  assign drive = (ph == PH_SETUP) || (ph == PH_PULSE) || (ph == PH_HOLD);
  assign ce_n  = !(drive || ph == PH_READ);
  assign we_n  = (ph != PH_PULSE);
  assign oe_n  = (ph != PH_READ);

  // write strobe only inside a selected cycle with outputs off (R3)
  p_we_guarded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && oe_n && drive));
  // address and data do not move while the chip is selected (R3)
  p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n) && $past(rst_n)) |-> ($stable(bus_addr) && $stable(bus_wdata)));
  // completion is flagged only once the bus is released (R3)
  p_fin_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (ce_n && oe_n && we_n));
endmodule

// File: rtl/page_write_poller.sv
module page_write_poller
  import pgp_pkg::*;
#(
  parameter int AW = 13,
  parameter int TW = 4,
  parameter int PAGE_BYTES = 64,
  parameter int TMO_CYCLES = 500000,
  parameter int WIN_CYCLES = 10000,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          poll_toggle,
  input  logic          protect_en,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] byte_cnt,
  input  logic [TW-1:0] t_setup,
  input  logic [TW-1:0] t_pulse,
  input  logic [TW-1:0] t_hold,
  input  logic [TW-1:0] t_read,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_drive,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [2:0]    err_code
);
  eng_state_e    st;
  logic          mode_q, have_prev, prev6, seen_fall;
  logic [AW-1:0] page_base, last_addr, go_addr;
  logic [CW-1:0] cnt_q, idx;
  logic [1:0]    pre_idx;
  logic [7:0]    last_data, go_data, rd_q;
  logic [15:0]   unlk_a;
  logic          go, go_rd, fin, we_fall;
  logic          tmo_exp, win_exp, tmo_restart, stall, last_byte, poll_ok;
  err_e          chk_code, code_q;

  pgp_req_check #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_check (
    .base(base_addr), .cnt(byte_cnt), .code(chk_code));

  pgp_bus_cycle #(.AW(AW), .TW(TW)) u_bus (
    .clk, .rst_n, .go, .rd(go_rd), .addr(go_addr), .wdata(go_data),
    .t_setup, .t_pulse, .t_hold, .t_read, .bus_rdata(mem_rdata),
    .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .drive(mem_drive),
    .bus_addr(mem_addr), .bus_wdata(mem_wdata), .fin, .we_fall, .rd_q);

  pgp_limit_timer #(.LIMIT(TMO_CYCLES)) u_tmo (
    .clk, .rst_n, .restart(tmo_restart),
    .run(st == S_PRD || st == S_PRDW), .expired(tmo_exp));

  pgp_limit_timer #(.LIMIT(WIN_CYCLES)) u_win (
    .clk, .rst_n, .restart(we_fall || (st == S_IDLE && start)),
    .run(1'b1), .expired(win_exp));

  always_comb begin
    go      = 1'b0;
    go_rd   = 1'b0;
    go_addr = last_addr;
    go_data = last_data;
    unlk_a  = unlock_addr(pre_idx);
    case (st)
      S_UNLK: begin go = 1'b1; go_addr = unlk_a[AW-1:0]; go_data = unlock_data(pre_idx); end
      S_WAIT: if (in_valid) begin go = 1'b1; go_addr = page_base + AW'(idx); go_data = in_data; end
      S_PRD:  begin go = 1'b1; go_rd = 1'b1; end
      default: ;
    endcase
  end

  assign in_ready    = (st == S_WAIT);
  assign busy        = (st != S_IDLE);
  assign err_code    = code_q;
  assign last_byte   = (idx == cnt_q - 1'b1);
  assign stall       = (st == S_WAIT) && !in_valid && seen_fall && win_exp;
  assign tmo_restart = (st == S_WR) && fin && last_byte;
  assign poll_ok     = mode_q ? (have_prev && (rd_q[6] == prev6))
                              : (rd_q[7] == last_data[7]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; mode_q <= 1'b0; page_base <= '0; cnt_q <= '0; idx <= '0;
      pre_idx <= '0; last_addr <= '0; last_data <= '0; have_prev <= 1'b0;
      prev6 <= 1'b0; seen_fall <= 1'b0; done <= 1'b0; err <= 1'b0; code_q <= ERR_NONE;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (we_fall) seen_fall <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          code_q <= chk_code;
          if (chk_code != ERR_NONE) err <= 1'b1;
          else begin
            mode_q <= poll_toggle; page_base <= base_addr; cnt_q <= byte_cnt;
            idx <= '0; pre_idx <= '0; seen_fall <= 1'b0; have_prev <= 1'b0;
            st <= protect_en ? S_UNLK : S_WAIT;
          end
        end
        S_UNLK:  st <= S_UNLKW;
        S_UNLKW: if (fin) begin
          if (pre_idx == UNLK_LAST) st <= S_WAIT;
          else begin pre_idx <= pre_idx + 1'b1; st <= S_UNLK; end
        end
        S_WAIT: if (in_valid) begin
          last_addr <= go_addr; last_data <= in_data; st <= S_WR;
        end else if (stall) begin
          err <= 1'b1; code_q <= ERR_STALL; st <= S_IDLE;
        end
        S_WR: if (fin) begin
          if (last_byte) st <= S_PRD;
          else begin idx <= idx + 1'b1; st <= S_WAIT; end
        end
        S_PRD:  st <= S_PRDW;
        S_PRDW: if (fin) begin
          if (poll_ok) begin done <= 1'b1; st <= S_IDLE; end
          else if (tmo_exp) begin err <= 1'b1; code_q <= ERR_TIMEOUT; st <= S_IDLE; end
          else begin prev6 <= rd_q[6]; have_prev <= 1'b1; st <= S_PRD; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // data bytes land inside the requested page (R4)
  p_page_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && !mem_we_n) |-> (mem_addr[AW-1:PW] == page_base[AW-1:PW]));
  // no byte is taken while a bus cycle is in flight (R4)
  p_ready_bus_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (mem_ce_n && mem_we_n && mem_oe_n));
  // polling never strobes a write (R7)
  p_poll_reads_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRDW) |-> mem_we_n);
  // outcome pulses are exclusive and come with busy low (R10)
  p_outcome_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> (!(done && err) && !busy));
  // an error always carries a nonzero code (R10)
  p_err_coded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (err_code != ERR_NONE));
  // a pulse lasts one cycle (R10)
  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> !(done || err));
endmodule

// File: tb/test_page_write_poller.sv
module test_page_write_poller;
  localparam int AW = 13, TW = 4, PB = 64, CW = 7, TMO = 3000, WIN = 200;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, poll_toggle, protect_en, in_valid, in_ready;
  logic [AW-1:0] base_addr, mem_addr;
  logic [CW-1:0] byte_cnt;
  logic [TW-1:0] t_s, t_p, t_h, t_r;
  logic [7:0] in_data, mem_wdata, mem_rdata;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_drive, busy, done, err;
  logic [2:0] err_code;

  page_write_poller #(.AW(AW), .TW(TW), .PAGE_BYTES(PB), .TMO_CYCLES(TMO), .WIN_CYCLES(WIN))
  i_page_write_poller (
    .clk, .rst_n, .start, .poll_toggle, .protect_en, .base_addr, .byte_cnt,
    .t_setup(t_s), .t_pulse(t_p), .t_hold(t_h), .t_read(t_r),
    .in_valid, .in_ready, .in_data, .mem_addr, .mem_wdata, .mem_rdata,
    .mem_ce_n, .mem_we_n, .mem_oe_n, .mem_drive, .busy, .done, .err, .err_code);

  int vecs = 0, miss = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  // behavioural device and bus-rule model
  int busy_left, busy_set, we_low, setup_run, hold_run, rd_run;
  bit in_hold, tog, prev_we, prev_oe;
  logic [7:0] lw;
  logic [AW-1:0] la;
  logic [AW+7:0] got_q[$];
  bit ev_seen, ev_done, ev_busy, pulse_prev;
  logic [2:0] ev_code;
  int ev_dev;

  assign mem_rdata = (mem_oe_n || mem_ce_n || mem_addr != la) ? 8'h00 :
                     (busy_left > 0) ? {~lw[7], tog, lw[5:0]} : lw;

  always @(negedge clk) begin
    if (!rst_n) begin
      busy_left = 0; we_low = 0; setup_run = 0; hold_run = 0; rd_run = 0;
      in_hold = 0; tog = 0; prev_we = 1; prev_oe = 1; lw = 0; la = 0; pulse_prev = 0;
    end else begin
      if (busy_left > 0) busy_left--;
      if (mem_ce_n) begin
        if (in_hold) chk(hold_run == int'(t_h) + 1, "R3 hold length", hold_run, int'(t_h) + 1);
        in_hold = 0; setup_run = 0; hold_run = 0;
      end
      if (!mem_ce_n && mem_we_n && mem_oe_n && !in_hold) setup_run++;
      if (!mem_we_n) begin
        chk(mem_oe_n && !mem_ce_n, "R3 strobes during write", {mem_ce_n, mem_oe_n}, 2'b01);
        if (prev_we) chk(setup_run == int'(t_s) + 1, "R3 setup length", setup_run, int'(t_s) + 1);
        we_low++;
      end
      if (mem_we_n && !prev_we) begin
        chk(we_low == int'(t_p) + 1, "R3 pulse length", we_low, int'(t_p) + 1);
        we_low = 0;
        got_q.push_back({mem_addr, mem_wdata});
        lw = mem_wdata; la = mem_addr; busy_left = busy_set;
        in_hold = 1; hold_run = 0;
      end
      if (in_hold && !mem_ce_n && mem_we_n) hold_run++;
      if (!mem_oe_n) begin
        if (prev_oe && busy_left > 0) tog = ~tog;
        chk(!mem_ce_n && mem_we_n, "R7 read strobes", {mem_ce_n, mem_we_n}, 2'b01);
        rd_run++;
      end
      if (mem_oe_n && !prev_oe) begin
        chk(rd_run == int'(t_r) + 1, "R7 read length", rd_run, int'(t_r) + 1);
        rd_run = 0;
      end
      if (pulse_prev) chk(!(done || err), "R10 pulse one cycle", {done, err}, 0);
      pulse_prev = done || err;
      if (done || err) begin
        ev_seen = 1; ev_done = done; ev_code = err_code; ev_busy = busy; ev_dev = busy_left;
        chk(!(done && err), "R10 exclusive", {done, err}, 2'b10);
      end
      prev_we = mem_we_n; prev_oe = mem_oe_n;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      vecs++; miss++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
    end
  end

  task automatic run_op(input bit tmode, input bit prot, input logic [AW-1:0] base, input int cnt,
                        input int bsy, input int stall_at, input bit poke, input logic [2:0] exp_code,
                        input string tag);
    logic [7:0] d[$];
    logic [AW+7:0] expw[$];
    int n, nw;
    got_q.delete(); ev_seen = 0; busy_set = bsy;
    for (int k = 0; k < cnt && k < PB + 2; k++) d.push_back(8'((k * 37 + base + cnt * 11) ^ 8'h5A));
    nw = (exp_code == 3'd4) ? stall_at : cnt;
    if (exp_code == 3'd0 || exp_code == 3'd3 || exp_code == 3'd4) begin
      if (prot) begin
        expw.push_back({13'h1555, 8'hAA}); expw.push_back({13'h0AAA, 8'h55});
        expw.push_back({13'h1555, 8'hA0});
      end
      for (int k = 0; k < nw; k++) expw.push_back({base + AW'(k), d[k]});
    end
    poll_toggle = tmode; protect_en = prot; base_addr = base; byte_cnt = CW'(cnt);
    start = 1; @(negedge clk); start = 0;
    if (exp_code == 3'd0 || exp_code == 3'd3 || exp_code == 3'd4) begin
      for (int k = 0; k < cnt; k++) begin
        if (exp_code == 3'd4 && k == stall_at) break;
        if (poke && k == 2) begin
          start = 1; byte_cnt = '0; @(negedge clk); start = 0; byte_cnt = CW'(cnt);
        end
        in_valid = 1; in_data = d[k];
        while (!in_ready) @(negedge clk);
        @(negedge clk);
      end
      in_valid = 0;
    end
    n = 0;
    while (!ev_seen && n < 20000) begin @(negedge clk); n++; end
    if (exp_code == 3'd0) begin
      chk(ev_seen && ev_done, {tag, " done reported"}, ev_code, 0);
      chk(ev_dev == 0, {tag, " R7 R8 done only after device ready"}, ev_dev, 0);
    end else begin
      chk(ev_seen && !ev_done && ev_code == exp_code, {tag, " error code"}, ev_code, exp_code);
    end
    chk(!ev_busy, {tag, " R10 busy low at outcome"}, ev_busy, 0);
    chk(got_q.size() == expw.size(), {tag, " R4 R5 write count"}, got_q.size(), expw.size());
    for (int k = 0; k < expw.size() && k < got_q.size(); k++)
      chk(got_q[k] == expw[k], {tag, " R4 R5 write addr/data"}, got_q[k], expw[k]);
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !busy, {tag, " bus released"},
        {mem_ce_n, mem_we_n, mem_oe_n, busy}, 4'b1110);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; start = 0; poll_toggle = 0; protect_en = 0; base_addr = '0; byte_cnt = '0;
    in_valid = 0; in_data = '0; t_s = 4'd2; t_p = 4'd3; t_h = 4'd1; t_r = 4'd2; busy_set = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(!busy && !in_ready && !done && !err, "R1 status low", {busy, in_ready, done, err}, 0);

    run_op(0, 0, 13'h0100, 4, 300, 0, 0, 3'd0, "R7 data poll");
    run_op(0, 1, 13'h1FC0, 64, 200, 0, 0, 3'd0, "R5 protect full page");
    t_s = 4'd0; t_p = 4'd0; t_h = 4'd0; t_r = 4'd0;
    run_op(1, 0, 13'h0A25, 5, 400, 0, 0, 3'd0, "R8 toggle poll");
    run_op(1, 1, 13'h003F, 1, 50, 0, 0, 3'd0, "R8 R5 single byte");
    t_s = 4'd1; t_p = 4'd2; t_h = 4'd3; t_r = 4'd1;
    run_op(0, 0, 13'h0200, 0, 10, 0, 0, 3'd1, "R2 zero count");
    run_op(0, 0, 13'h0200, 65, 10, 0, 0, 3'd1, "R2 count over page");
    run_op(0, 0, 13'h0041, 64, 10, 0, 0, 3'd2, "R2 page cross");
    run_op(0, 0, 13'h0041, 63, 10, 0, 0, 3'd0, "R2 R4 page end boundary");
    run_op(0, 0, 13'h0300, 2, 6000, 0, 0, 3'd3, "R9 data timeout");
    run_op(1, 1, 13'h0400, 2, 6000, 0, 0, 3'd3, "R9 toggle timeout");
    run_op(0, 0, 13'h0500, 6, 100, 3, 0, 3'd4, "R6 stream stall");
    run_op(1, 0, 13'h0600, 5, 120, 0, 1, 3'd0, "R11 start while busy");
    summary();
  end
endmodule